// File: doc/BRIEF.md
# I2C Reserved-Code Command Handler

This block sits beside the byte engine of an I2C memory target and decodes the reserved target codes. The bus front end reports START and STOP events, each byte received from the controller, and the controller's acknowledge bit after each byte the target sends. The handler answers with an acknowledge request, a byte for the transmit shifter, a high-speed-mode flag, a sleep flag, and a hold signal. The hold signal tells the memory engine to refuse its own address while the device sleeps or is recovering.

A reserved command is reached through a selection step. The controller sends the select code F8h and then this device's own address, in which the R/W bit does not matter. After a repeated START it sends one of two command codes. F9h starts a read of a fixed three-byte identity word. 86h arms sleep, which takes effect at the next STOP. A sleeping device keeps decoding first bytes. A matching address clears sleep and starts a recovery window of `REC_CYCLES` clocks, and addressing is refused until that window ends. A first byte of the form 0000_1xxx is the high-speed controller code. It raises a flag that the front end uses to switch its timing.

Top module: `rac_cmd_handler`

## Requirements
- R1: After reset, `ack_req`, `tx_en`, `hs_mode`, `sleep`, `wake_busy` and `mem_hold` are all 0.
- R2: A first byte after START whose upper five bits are 00001 sets `hs_mode` and leaves `ack_req` at 0. The flag survives repeated STARTs and later bytes, and the next STOP clears it.
- R3: `ack_req` is updated in the cycle after each received byte and cleared by START or STOP. A first byte of F8h is acknowledged when `mem_hold` is 0. The next byte is acknowledged only if its bits 7:1 equal {1010b, `strap_addr`}, whatever bit 0 is.
- R4: After a completed selection and a repeated START, F9h is acknowledged and `tx_en` rises. `tx_byte` gives the identity word: 12 maker bits, then 9 part bits, then 3 revision bits, sent MSB first. With the defaults these are 00h, 41h, 00h. Each controller ACK advances one byte, and every byte after the last reads 00h.
- R5: A controller NACK during the identity read drops `tx_en` and ends the command. A later F9h without a new selection is not acknowledged.
- R6: After a completed selection and a repeated START, 86h is acknowledged. A STOP that directly follows it sets `sleep`, and a START that directly follows it does not.
- R7: A STOP, a START or any unexpected byte in the middle of the selection sequence sends the handler back to idle. A START during the identity read ends the read.
- R8: While `sleep` is 1, a first byte matching {1010b, `strap_addr`} with either R/W value clears `sleep`, is not acknowledged by the handler, and holds `wake_busy` high for exactly `REC_CYCLES` clocks. A non-matching address leaves `sleep` set.
- R9: `mem_hold` is 1 during sleep and recovery. While it is 1, F8h is not acknowledged. Once recovery ends, F8h is acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Pulse: START or repeated START seen |
| bus_stop | input | 1 | Pulse: STOP seen |
| rx_valid | input | 1 | Pulse: a byte from the controller is complete |
| rx_byte | input | 8 | The received byte, valid with `rx_valid` |
| host_ack_valid | input | 1 | Pulse: acknowledge slot after a transmitted byte |
| host_ack | input | 1 | 1 = controller acknowledged, 0 = NACK |
| strap_addr | input | STRAP_W | Device-select strap pins |
| ack_req | output | 1 | Handler asks the front end to acknowledge the last byte |
| tx_en | output | 1 | Handler owns the transmit shifter (identity read) |
| tx_byte | output | 8 | Byte to shift out while `tx_en` is 1 |
| hs_mode | output | 1 | High-speed controller code seen, until STOP |
| sleep | output | 1 | Device is asleep |
| wake_busy | output | 1 | Recovery window after wake-up is running |
| mem_hold | output | 1 | Memory engine must NACK its address |

## Verification
The bench sweeps all 256 first-byte values and, for each of the eight strap settings, all 256 address bytes after F8h. A wrong high-speed mask or a select decode that looked at the R/W bit would acknowledge or flag the wrong codes. It reads the identity word past its end and then NACKs. A handler that wrapped the byte index would repeat 00h 41h, and one that missed the NACK would keep driving the bus. It also breaks the sequence with STOP, START and stray bytes, and times the recovery window clock by clock. A design that skipped the reset to idle, or was off by one in the recovery count, would then enter sleep or identity mode by mistake, or lift the hold a clock early or late.

// File: rtl/rac_pkg.sv
package rac_pkg;
   localparam logic [7:0] CODE_SELECT = 8'hF8;
   localparam logic [7:0] CODE_IDENT  = 8'hF9;
   localparam logic [7:0] CODE_SLEEP  = 8'h86;
   localparam logic [4:0] CODE_HS_TOP = 5'b00001;
   localparam logic [3:0] MEM_TYPE    = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FIRST,
      ST_SEL_ADR,
      ST_SEL_GAP,
      ST_CMD,
      ST_ID,
      ST_SLP_ARM
   } rac_state_e;
endpackage

// File: rtl/rac_code_dec.sv
module rac_code_dec
   import rac_pkg::*;
#(
   parameter int STRAP_W = 3
) (
   input  logic [7:0]         code,
   input  logic [STRAP_W-1:0] strap,
   output logic               is_hs,
   output logic               is_sel,
   output logic               is_id,
   output logic               is_slp,
   output logic               is_own
);
   assign is_hs  = (code[7:3] == CODE_HS_TOP);
   assign is_sel = (code == CODE_SELECT);
   assign is_id  = (code == CODE_IDENT);
   assign is_slp = (code == CODE_SLEEP);
   assign is_own = (code[7:1] == {MEM_TYPE, strap});
endmodule

// File: rtl/rac_id_src.sv
module rac_id_src #(
   parameter int ID_BITS  = 24,
   parameter int ID_BYTES = 3,
   parameter int IDX_W    = 2
) (
   input  logic [ID_BITS-1:0] id_word,
   input  logic [IDX_W-1:0]   idx,
   output logic [7:0]         id_byte
);
   localparam int PAD = ID_BYTES * 8 - ID_BITS;

   logic [ID_BYTES*8-1:0] padded;
   logic [7:0]            slice [ID_BYTES];

   generate
      if (PAD == 0) begin : g_exact
         assign padded = id_word;
      end else begin : g_pad
         assign padded = {id_word, {PAD{1'b0}}};
      end
      for (genvar k = 0; k < ID_BYTES; k++) begin : g_slice
         assign slice[k] = padded[(ID_BYTES-1-k)*8 +: 8];
      end
   endgenerate

   always_comb begin
      id_byte = 8'h00;
      for (int k = 0; k < ID_BYTES; k++) begin
         if (idx == IDX_W'(k)) id_byte = slice[k];
      end
   end
endmodule

// File: rtl/rac_wake_timer.sv
module rac_wake_timer #(
   parameter int REC_CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);
   generate
      if (REC_CYCLES == 0) begin : g_none
         logic unused_go;
         assign unused_go = go;
         assign busy      = 1'b0;
      end else begin : g_count
         localparam int CNT_W = $clog2(REC_CYCLES + 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt <= '0;
            else if (go)             cnt <= CNT_W'(REC_CYCLES);
            else if (cnt != '0)      cnt <= cnt - 1'b1;
         end
         assign busy = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/rac_cmd_handler.sv
module rac_cmd_handler
   import rac_pkg::*;
#(
   parameter int          STRAP_W    = 3,
   parameter int          MAKER_W    = 12,
   parameter int          PART_W     = 9,
   parameter int          REV_W      = 3,
   parameter logic [11:0] MAKER_ID   = 12'h004,
   parameter logic [8:0]  PART_ID    = 9'h020,
   parameter logic [2:0]  REV_ID     = 3'h0,
   parameter int          REC_CYCLES = 20000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_start,
   input  logic               bus_stop,
   input  logic               rx_valid,
   input  logic [7:0]         rx_byte,
   input  logic               host_ack_valid,
   input  logic               host_ack,
   input  logic [STRAP_W-1:0] strap_addr,
   output logic               ack_req,
   output logic               tx_en,
   output logic [7:0]         tx_byte,
   output logic               hs_mode,
   output logic               sleep,
   output logic               wake_busy,
   output logic               mem_hold
);
   localparam int ID_BITS  = MAKER_W + PART_W + REV_W;
   localparam int ID_BYTES = (ID_BITS + 7) / 8;
   localparam int IDX_W    = $clog2(ID_BYTES + 1);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(ID_BYTES);

   generate
      if (STRAP_W != 3)
         $error("STRAP_W must be 3: the address byte is type(4) strap(3) rw(1)");
      if (MAKER_W != 12 || PART_W != 9 || REV_W != 3)
         $error("identity field widths must match the ID parameter widths");
      if (ID_BYTES > 16)
         $error("identity word longer than 16 bytes");
   endgenerate

   logic is_hs, is_sel, is_id, is_slp, is_own;
   logic wake_go;
   rac_state_e st, st_n;
   logic ack_n, hs_n, slp_n;
   logic [IDX_W-1:0] idx, idx_n;

   rac_code_dec #(.STRAP_W(STRAP_W)) u_dec (
      .code   (rx_byte),
      .strap  (strap_addr),
      .is_hs  (is_hs),
      .is_sel (is_sel),
      .is_id  (is_id),
      .is_slp (is_slp),
      .is_own (is_own)
   );

   rac_id_src #(.ID_BITS(ID_BITS), .ID_BYTES(ID_BYTES), .IDX_W(IDX_W)) u_id (
      .id_word ({MAKER_ID, PART_ID, REV_ID}),
      .idx     (idx),
      .id_byte (tx_byte)
   );

   rac_wake_timer #(.REC_CYCLES(REC_CYCLES)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (wake_go),
      .busy  (wake_busy)
   );

   assign mem_hold = sleep | wake_busy;
   assign tx_en    = (st == ST_ID);

   always_comb begin
      st_n    = st;
      ack_n   = ack_req;
      hs_n    = hs_mode;
      slp_n   = sleep;
      idx_n   = idx;
      wake_go = 1'b0;
      if (bus_stop) begin
         st_n  = ST_IDLE;
         ack_n = 1'b0;
         hs_n  = 1'b0;
         if (st == ST_SLP_ARM) slp_n = 1'b1;
      end else if (bus_start) begin
         ack_n = 1'b0;
         st_n  = (st == ST_SEL_GAP) ? ST_CMD : ST_FIRST;
      end else if (rx_valid) begin
         ack_n = 1'b0;
         st_n  = ST_IDLE;
         case (st)
            ST_FIRST: begin
               if (is_hs) begin
                  hs_n = 1'b1;
               end else if (is_sel && !mem_hold) begin
                  ack_n = 1'b1;
                  st_n  = ST_SEL_ADR;
               end else if (is_own && sleep) begin
                  slp_n   = 1'b0;
                  wake_go = 1'b1;
               end
            end
            ST_SEL_ADR: begin
               if (is_own) begin
                  ack_n = 1'b1;
                  st_n  = ST_SEL_GAP;
               end
            end
            ST_CMD: begin
               if (is_id) begin
                  ack_n = 1'b1;
                  st_n  = ST_ID;
                  idx_n = '0;
               end else if (is_slp) begin
                  ack_n = 1'b1;
                  st_n  = ST_SLP_ARM;
               end
            end
            default: ;
         endcase
      end else if (host_ack_valid && st == ST_ID) begin
         ack_n = 1'b0;
         if (!host_ack)            st_n  = ST_IDLE;
         else if (idx != IDX_END)  idx_n = idx + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ack_req <= 1'b0;
         hs_mode <= 1'b0;
         sleep   <= 1'b0;
         idx     <= '0;
      end else begin
         st      <= st_n;
         ack_req <= ack_n;
         hs_mode <= hs_n;
         sleep   <= slp_n;
         idx     <= idx_n;
      end
   end
endmodule

// File: rtl/rac_cmd_checker.sv
module rac_cmd_checker #(
   parameter int REC_CYCLES = 20000
) (
   input logic clk,
   input logic rst_n,
   input logic bus_start,
   input logic bus_stop,
   input logic rx_valid,
   input logic ack_req,
   input logic tx_en,
   input logic hs_mode,
   input logic sleep,
   input logic wake_busy,
   input logic mem_hold
);
   // R2: STOP always ends high-speed mode
   p_hs_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !hs_mode);
   // R2: the high-speed code is never acknowledged
   p_hs_noack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_mode) |-> !ack_req);
   // R6: sleep is only entered on a STOP
   p_sleep_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep) |-> $past(bus_stop));
   // R9: no acknowledge for bytes seen while held
   p_hold_noack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_hold && rx_valid) |=> !ack_req);
   // R7: START ends any readout and clears the acknowledge request
   p_start_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (!tx_en && !ack_req));
   // R8: leaving sleep starts recovery
   p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep) |-> (wake_busy || REC_CYCLES == 0));
   // R4: identity readout only happens while awake
   p_tx_awake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> !mem_hold);
endmodule

bind rac_cmd_handler rac_cmd_checker #(.REC_CYCLES(REC_CYCLES)) i_rac_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_start (bus_start),
   .bus_stop  (bus_stop),
   .rx_valid  (rx_valid),
   .ack_req   (ack_req),
   .tx_en     (tx_en),
   .hs_mode   (hs_mode),
   .sleep     (sleep),
   .wake_busy (wake_busy),
   .mem_hold  (mem_hold)
);

// File: tb/test_rac_cmd_handler.sv
module test_rac_cmd_handler;
   localparam int REC = 20;
   localparam logic [23:0] ID_WORD = {12'h004, 9'h020, 3'h0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_start = 0, bus_stop = 0, rx_valid = 0, host_ack_valid = 0, host_ack = 0;
   logic [7:0] rx_byte = 0;
   logic [2:0] strap_addr = 3'b101;
   logic ack_req, tx_en, hs_mode, sleep, wake_busy, mem_hold;
   logic [7:0] tx_byte;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   rac_cmd_handler #(.REC_CYCLES(REC)) i_rac_cmd_handler (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .host_ack_valid(host_ack_valid),
      .host_ack(host_ack), .strap_addr(strap_addr), .ack_req(ack_req),
      .tx_en(tx_en), .tx_byte(tx_byte), .hs_mode(hs_mode), .sleep(sleep),
      .wake_busy(wake_busy), .mem_hold(mem_hold));

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_start();
      @(negedge clk) bus_start = 1;
      @(negedge clk) bus_start = 0;
   endtask
   task automatic do_stop();
      @(negedge clk) bus_stop = 1;
      @(negedge clk) bus_stop = 0;
   endtask
   task automatic do_byte(input logic [7:0] b);
      @(negedge clk) begin rx_valid = 1; rx_byte = b; end
      @(negedge clk) rx_valid = 0;
   endtask
   task automatic do_hack(input logic a);
      @(negedge clk) begin host_ack_valid = 1; host_ack = a; end
      @(negedge clk) host_ack_valid = 0;
   endtask
   function automatic logic [7:0] own(input logic [2:0] s, input logic rw);
      return {4'b1010, s, rw};
   endfunction
   task automatic do_select();
      do_start(); do_byte(8'hF8); do_byte(own(strap_addr, 1'b0)); do_start();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk({ack_req, tx_en, hs_mode, sleep, wake_busy, mem_hold} == 6'b0, "R1",
          {ack_req, tx_en, hs_mode, sleep, wake_busy, mem_hold}, 0);

      // R2 / R3: sweep every first byte
      for (int b = 0; b < 256; b++) begin
         do_start(); do_byte(8'(b));
         chk(ack_req == (b == 'hF8), "R3 first-byte ack", ack_req, b == 'hF8);
         chk(hs_mode == ((b >> 3) == 1), "R2 hs decode", hs_mode, (b >> 3) == 1);
         do_stop();
         chk(!hs_mode && !ack_req, "R2 stop clears", hs_mode, 0);
      end

      // R2: persistence across repeated START and bytes
      do_start(); do_byte(8'h0B);
      chk(hs_mode && !ack_req, "R2 hs set no ack", {hs_mode, ack_req}, 2);
      do_start();
      chk(hs_mode, "R2 hs after restart", hs_mode, 1);
      do_byte(8'hF8);
      chk(hs_mode && ack_req, "R2 hs with transfer", {hs_mode, ack_req}, 3);
      do_stop();
      chk(!hs_mode, "R2 hs cleared", hs_mode, 0);

      // R3: address sweep over all strap settings
      for (int s = 0; s < 8; s++) begin
         strap_addr = 3'(s);
         for (int a = 0; a < 256; a++) begin
            do_start(); do_byte(8'hF8); do_byte(8'(a));
            chk(ack_req == ((a >> 1) == ('hA << 3 | s)), "R3 select addr", ack_req,
                (a >> 1) == ('hA << 3 | s));
            do_stop();
         end
      end
      strap_addr = 3'b101;

      // R4 / R5: identity read past the end then NACK
      do_select(); do_byte(8'hF9);
      chk(ack_req && tx_en, "R4 F9 ack", {ack_req, tx_en}, 3);
      for (int k = 0; k < 5; k++) begin
         automatic int exp = (k < 3) ? int'((ID_WORD >> (8 * (2 - k))) & 24'hFF) : 0;
         chk(tx_en && tx_byte == 8'(exp), "R4 id byte", tx_byte, exp);
         if (k == 1) chk(tx_byte == 8'h41, "R4 part byte", tx_byte, 'h41);
         do_hack(k < 4);
      end
      chk(!tx_en, "R5 nack ends read", tx_en, 0);
      do_start(); do_byte(8'hF9);
      chk(!ack_req && !tx_en, "R5 F9 without select", ack_req, 0);
      do_stop();

      // R7: broken sequences
      do_select(); do_byte(8'hF9); do_hack(1'b1); do_start();
      chk(!tx_en, "R7 start ends read", tx_en, 0);
      do_stop();
      do_start(); do_byte(8'hF8); do_byte(own(strap_addr, 1'b1)); do_stop();
      do_start(); do_byte(8'hF9);
      chk(!ack_req && !tx_en, "R7 stop mid-select", ack_req, 0);
      do_stop();
      do_start(); do_byte(8'hF8); do_byte(own(strap_addr, 1'b0)); do_byte(8'h00);
      do_start(); do_byte(8'hF9);
      chk(!ack_req, "R7 stray byte", ack_req, 0);
      do_stop();
      do_select(); do_byte(8'h86);
      chk(ack_req, "R6 86 ack", ack_req, 1);
      do_start(); do_stop();
      chk(!sleep, "R6 start cancels sleep", sleep, 0);

      // R6: sleep entry
      do_select(); do_byte(8'h86); do_stop();
      chk(sleep && mem_hold, "R6 sleep set", {sleep, mem_hold}, 3);

      // R9 / R8 while asleep
      do_start(); do_byte(8'hF8);
      chk(!ack_req, "R9 F8 refused asleep", ack_req, 0);
      do_stop();
      do_start(); do_byte(own(3'b010, 1'b0));
      chk(sleep, "R8 other address keeps sleep", sleep, 1);
      do_stop();

      // R8: wake and exact recovery length
      do_start(); do_byte(own(strap_addr, 1'b1));
      chk(!sleep && wake_busy && !ack_req, "R8 wake begins", {sleep, wake_busy, ack_req}, 2);
      chk(mem_hold, "R9 hold in recovery", mem_hold, 1);
      begin
         automatic int n = 0;
         while (wake_busy && n < 1000) begin @(negedge clk); n++; end
         chk(n == REC, "R8 recovery length", n, REC);
      end
      chk(!mem_hold, "R9 hold released", mem_hold, 0);
      do_stop();

      // R9: F8 refused during recovery, accepted after
      do_select(); do_byte(8'h86); do_stop();
      do_start(); do_byte(own(strap_addr, 1'b0));
      do_start(); do_byte(8'hF8);
      chk(!ack_req && wake_busy, "R9 F8 refused in recovery", ack_req, 0);
      do_stop();
      repeat (REC + 2) @(negedge clk);
      do_start(); do_byte(8'hF8);
      chk(ack_req, "R9 F8 after recovery", ack_req, 1);
      do_stop();

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule